// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block decides when a customer has paid enough for one item. Each coin arrives as a single-cycle strobe together with its value. The block keeps a running total and raises a one-cycle dispense pulse as soon as the total reaches or passes the item price. The total is then cleared and the block waits for the next purchase.

The design is a finite state machine with datapath. The datapath holds the total register, an adder that forms the total plus the coin value, and a magnitude comparator. The comparator produces a single status bit that is high when the total is below the price. The controller never handles data itself. It sets the register's clear and load controls, and it reads only that status bit. The coin value must stay stable for the cycle after its strobe, because the addition happens in that cycle. Coin validation, change return, price setting and any display are handled elsewhere.

Top module: `vend_fsmd`

## Requirements
- R1: Reset is synchronous and active-low (`rst_n`). While it is low, `dispense` is 0. After it is released, the total is zero, so credit from before the reset is discarded.
- R2: Each `coin` pulse that arrives while the block is idle adds `coin_val` to the total exactly once. `coin_val` must be held for the following cycle.
- R3: If a coin pulse sampled at clock edge k brings the total above the price, `dispense` is 1 from edge k+2 to edge k+3 and 0 again after edge k+3.
- R4: While the total is below `price`, `dispense` stays 0, even when the block idles for many cycles.
- R5: A total exactly equal to `price` counts as paid and dispenses with the same timing as R3.
- R6: After a dispense, the total is cleared. The next item needs the full price again, and coins are accepted from the third edge after the dispense pulse begins.
- R7: With `price` equal to 0, the block dispenses every third cycle without any coin.
- R8: The controller never asserts the total clear and total load controls in the same cycle. It loads only in the cycle after an accepted coin, and it dispenses only after the comparator reports that the total is not below the price.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| coin | input | 1 | One-cycle strobe per deposited coin |
| coin_val | input | 8 | Value of the deposited coin, held one cycle past the strobe |
| price | input | 8 | Price of one item |
| dispense | output | 1 | One-cycle pulse that releases one item |

## Verification
Some behaviours are checked by assertions on every cycle:
- the clear and load controls are never active together;
- a load only ever follows an accepted coin;
- the dispense pulse lasts one cycle, is always followed by a clear, and always comes after a not-below-price status;
- a cleared total reads zero.

Other behaviours can only be shown by the bench scenarios:
- dispense comes at exactly the right edge for exact and overpaid totals;
- partial credit never dispenses, even over long idle gaps;
- a reset drops partial credit;
- a zero price keeps dispensing on its own.

// File: rtl/vend_pkg.sv
// Shared types for the vending controller.
// Assumes nothing beyond a two-bit state encoding.
package vend_pkg;
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_WAIT = 2'd1,
        ST_ADD  = 2'd2,
        ST_DISP = 2'd3
    } vend_state_t;
endpackage

// File: rtl/vend_datapath.sv
// Datapath of the vending controller: a total register, an adder and a
// less-than comparator against the price.
// Assumes the controller never asks for clear and load together. The sum
// wraps modulo 2**W.
module vend_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tot_clr,
    input  logic         tot_ld,
    input  logic [W-1:0] coin_val,
    input  logic [W-1:0] price,
    output logic         tot_lt
);
    logic [W-1:0] total_q;
    logic [W-1:0] sum;

    // Adder: the running total plus the coin being credited.
    always_comb sum = total_q + coin_val;

    // Comparator: status bit for the controller.
    always_comb tot_lt = (total_q < price);

    // Total register with synchronous reset, clear and load.
    always_ff @(posedge clk) begin
        if (!rst_n || tot_clr) total_q <= '0;
        else if (tot_ld)       total_q <= sum;
    end

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tot_clr |=> (total_q == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tot_clr && !tot_ld) |=> $stable(total_q));
endmodule

// File: rtl/vend_control.sv
// Controller of the vending controller. It drives the clear and load
// controls of the total register and reads one status bit (total < price).
// Assumes a coin strobe is one cycle wide and is honoured only while idle.
module vend_control
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic coin,
    input  logic tot_lt,
    output logic tot_clr,
    output logic tot_ld,
    output logic dispense
);
    vend_state_t state_q, state_d;

    // Next-state logic of the four-state controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: state_d = ST_WAIT;
            ST_WAIT: begin
                if (coin)         state_d = ST_ADD;
                else if (!tot_lt) state_d = ST_DISP;
            end
            ST_ADD:  state_d = ST_WAIT;
            ST_DISP: state_d = ST_INIT;
            default: state_d = ST_INIT;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // Moore decode of the datapath controls and the dispense output.
    always_comb begin
        tot_clr  = (state_q == ST_INIT);
        tot_ld   = (state_q == ST_ADD);
        dispense = (state_q == ST_DISP);
    end

    assert_ctrl_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tot_clr && tot_ld));

    assert_load_after_coin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tot_ld) |-> $past(coin));

    assert_disp_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dispense |=> !dispense);

    assert_disp_then_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dispense |=> tot_clr);

    assert_disp_needs_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dispense) |-> !$past(tot_lt));
endmodule

// File: rtl/vend_fsmd.sv
// Top of the vending controller: connects the controller to the datapath.
// Assumes coin_val is held for the cycle after each coin strobe.
module vend_fsmd #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         coin,
    input  logic [W-1:0] coin_val,
    input  logic [W-1:0] price,
    output logic         dispense
);
    logic tot_clr, tot_ld, tot_lt;

    vend_control u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .coin     (coin),
        .tot_lt   (tot_lt),
        .tot_clr  (tot_clr),
        .tot_ld   (tot_ld),
        .dispense (dispense)
    );

    vend_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tot_clr  (tot_clr),
        .tot_ld   (tot_ld),
        .coin_val (coin_val),
        .price    (price),
        .tot_lt   (tot_lt)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !dispense);
endmodule

// File: tb/vend_fsmd_tb.sv
module vend_fsmd_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coin = 1'b0;
    logic [7:0] coin_val = 8'd0;
    logic [7:0] price = 8'd50;
    logic       dispense;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    bit    done     = 1'b0;
    string cur_req  = "R4";

    typedef struct {
        int    at;
        string req;
    } exp_t;
    exp_t exp_q[$];

    vend_fsmd #(.W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .coin(coin),
        .coin_val(coin_val), .price(price), .dispense(dispense)
    );

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Driver: called at a negedge with the controller idle; returns at the
    // negedge where the new total is visible to the comparator.
    task automatic put_coin(input logic [7:0] v);
        coin = 1'b1;
        coin_val = v;
        @(negedge clk);
        coin = 1'b0;
        @(negedge clk);
    endtask

    // Predict a sale one cycle on, then wait until coins are accepted again.
    task automatic expect_sale(input string r);
        exp_t e;
        e.at = cyc + 1;
        e.req = r;
        exp_q.push_back(e);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops predicted sales and compares them against dispense.
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                chk(1'b0, exp_q[0].req, 0, 1);
                void'(exp_q.pop_front());
            end
            if (dispense) begin
                if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
                    chk(1'b1, exp_q[0].req, 1, 1);
                    void'(exp_q.pop_front());
                end else begin
                    chk(1'b0, cur_req, 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        // R1: dispense stays low while reset is held
        repeat (3) begin
            @(negedge clk);
            chk(dispense == 1'b0, "R1", dispense, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R5: exact payment in three coins
        cur_req = "R5";
        price = 8'd50;
        put_coin(8'd20);
        put_coin(8'd20);
        put_coin(8'd10);
        expect_sale("R5");

        // R3: overpayment
        cur_req = "R3";
        put_coin(8'd40);
        put_coin(8'd40);
        expect_sale("R3");
        put_coin(8'd100);
        expect_sale("R3");

        // R2: five equal coins; a double add would sell early
        cur_req = "R2";
        repeat (4) put_coin(8'd10);
        put_coin(8'd10);
        expect_sale("R2");

        // R4: partial credit over a long idle gap
        cur_req = "R4";
        put_coin(8'd25);
        put_coin(8'd24);
        repeat (20) @(negedge clk);
        put_coin(8'd1);
        expect_sale("R5");

        // R6: total cleared after a sale
        cur_req = "R6";
        put_coin(8'd49);
        repeat (5) @(negedge clk);
        put_coin(8'd1);
        expect_sale("R6");

        // R1: reset mid-purchase drops credit
        cur_req = "R1";
        price = 8'd60;
        put_coin(8'd30);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dispense == 1'b0, "R1", dispense, 0);
        rst_n = 1'b1;
        @(negedge clk);
        put_coin(8'd30);
        repeat (4) @(negedge clk);
        put_coin(8'd30);
        expect_sale("R1");

        // R5: large totals at the top of the range
        cur_req = "R5";
        price = 8'd200;
        put_coin(8'd100);
        put_coin(8'd100);
        expect_sale("R5");
        price = 8'd255;
        repeat (4) put_coin(8'd51);
        put_coin(8'd51);
        expect_sale("R5");

        // R7: zero price dispenses every third cycle
        cur_req = "R7";
        price = 8'd0;
        for (int i = 0; i < 3; i++) begin
            exp_t e;
            e.at = cyc + 1 + 3 * i;
            e.req = "R7";
            exp_q.push_back(e);
        end
        repeat (7) @(negedge clk);
        price = 8'd200;
        cur_req = "R4";
        repeat (8) @(negedge clk);

        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule